// File: doc/BRIEF.md
# SIMD Instruction Exception Gate

This block sits at the dispatch point for packed-integer SIMD instructions whose registers share storage with the floating-point register stack. For each presented instruction it picks one outcome: let the instruction execute, or turn it into an exception request. The request is invalid opcode when emulation is enabled, device not available when the task-switched flag is set, or floating-point error when an earlier floating-point exception is still waiting to be serviced.

A floating-point error is handled as a trap taken before the SIMD instruction runs. The gate keeps the instruction parked and grants nothing while the handler runs, so the shared register state stays as the handler expects to see it. When the handler signals its return, the same instruction is tried again and the full priority check is applied afresh. The pending floating-point condition is a sticky bit inside the gate. It is set by the floating-point unit and cleared only by the handler.

Top module: `simd_xgate`

## Requirements
- R1: An instruction tried with the emulation flag set produces, one cycle later, an invalid-opcode request on `exc_req_o[0]` and no grant.
- R2: An instruction tried with the emulation flag clear and the task-switched flag set produces, one cycle later, a device-not-available request on `exc_req_o[1]` and no grant.
- R3: An instruction tried with both control flags clear while the pending bit is set produces, one cycle later, a floating-point error request on `exc_req_o[2]`. `held_o` rises in that same cycle.
- R4: While `held_o` is high and no handler return is given, `insn_valid_i` is ignored: no grant and no request appear, and the instruction stays held.
- R5: A handler return while held retries the parked instruction with the current flags and pending bit. If they are all clear, the grant pulses one cycle later and `held_o` falls. If the pending bit is still set, the floating-point error request pulses again and the instruction stays held.
- R6: The priority order is emulation, then task-switched, then pending error. At most one of the grant and the three request bits is high in any cycle.
- R7: The pending bit is set by `fpx_set_i` and cleared only by `fpx_clr_i`. When both arrive in the same cycle, set wins. A handler return does not clear it.
- R8: The grant and the request bits are single-cycle pulses. They appear only in the cycle after an attempt: a valid instruction while not held, or a handler return while held.
- R9: A synchronous reset clears the held instruction, the pending bit and all outputs.
- R10: A handler return while nothing is held has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | A SIMD instruction is presented for dispatch |
| ctl_em_i | input | 1 | Emulation control flag |
| ctl_ts_i | input | 1 | Task-switched control flag |
| fpx_set_i | input | 1 | Floating-point unit reports a new unserviced exception |
| fpx_clr_i | input | 1 | Handler clears the pending floating-point exception |
| hdl_ret_i | input | 1 | Handler return; releases the parked instruction for a retry |
| grant_o | output | 1 | Execute-grant pulse; the only enable for updating the shared register state |
| exc_req_o | output | 3 | One-hot exception request: bit 0 invalid opcode, bit 1 device not available, bit 2 floating-point error |
| held_o | output | 1 | An instruction is parked behind a floating-point error trap |

## Verification
The assertions assume that reset is applied at the first clock edge and that every input is a known value at each edge. They also assume that the dispatch logic upstream may present an instruction in any cycle, even while one is held. Nothing is assumed about how flags, set, clear or return combine. The bench therefore keeps every input defined from time zero, holds reset for the opening cycles, and in its random phase drives all six inputs independently. This includes returns while idle, instructions while held, and set and clear in the same cycle.

// File: rtl/simd_xgate_pkg.sv
package simd_xgate_pkg;

    localparam int EXC_W  = 3;
    localparam int EXC_UD = 0;
    localparam int EXC_NM = 1;
    localparam int EXC_MF = 2;

    typedef enum logic [2:0] {
        V_NONE  = 3'd0,
        V_GRANT = 3'd1,
        V_UD    = 3'd2,
        V_NM    = 3'd3,
        V_MF    = 3'd4
    } verdict_e;

    typedef struct packed {
        logic             held;
        logic             grant;
        logic [EXC_W-1:0] exc;
    } seq_state_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;

endpackage

// File: rtl/simd_xgate_prio.sv
module simd_xgate_prio
    import simd_xgate_pkg::*;
(
    input  logic     attempt_i,
    input  logic     em_i,
    input  logic     ts_i,
    input  logic     pend_i,
    output verdict_e verdict_o
);

    always_comb begin
        if (!attempt_i) begin
            verdict_o = V_NONE;
        end else if (em_i) begin
            verdict_o = V_UD;
        end else if (ts_i) begin
            verdict_o = V_NM;
        end else if (pend_i) begin
            verdict_o = V_MF;
        end else begin
            verdict_o = V_GRANT;
        end
    end

endmodule

// File: rtl/simd_xgate_pend.sv
module simd_xgate_pend
    import simd_xgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.pend = 1'b1;
        end else if (clr_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/simd_xgate_seq.sv
module simd_xgate_seq
    import simd_xgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid_i,
    input  logic             hdl_ret_i,
    input  verdict_e         verdict_i,
    output logic             attempt_o,
    output logic             grant_o,
    output logic [EXC_W-1:0] exc_o,
    output logic             held_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        attempt_o = st_q.held ? hdl_ret_i : insn_valid_i;
    end

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.exc   = '0;
        unique case (verdict_i)
            V_GRANT: begin
                st_d.grant = 1'b1;
                st_d.held  = 1'b0;
            end
            V_UD: begin
                st_d.exc[EXC_UD] = 1'b1;
                st_d.held        = 1'b0;
            end
            V_NM: begin
                st_d.exc[EXC_NM] = 1'b1;
                st_d.held        = 1'b0;
            end
            V_MF: begin
                st_d.exc[EXC_MF] = 1'b1;
                st_d.held        = 1'b1;
            end
            default: begin
                st_d.held = st_q.held;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;
    assign exc_o   = st_q.exc;
    assign held_o  = st_q.held;

endmodule

// File: rtl/simd_xgate.sv
module simd_xgate
    import simd_xgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid_i,
    input  logic             ctl_em_i,
    input  logic             ctl_ts_i,
    input  logic             fpx_set_i,
    input  logic             fpx_clr_i,
    input  logic             hdl_ret_i,
    output logic             grant_o,
    output logic [EXC_W-1:0] exc_req_o,
    output logic             held_o
);

    logic     fpx_pend;
    logic     attempt;
    verdict_e verdict;

    simd_xgate_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (fpx_set_i),
        .clr_i  (fpx_clr_i),
        .pend_o (fpx_pend)
    );

    simd_xgate_prio u_prio (
        .attempt_i (attempt),
        .em_i      (ctl_em_i),
        .ts_i      (ctl_ts_i),
        .pend_i    (fpx_pend),
        .verdict_o (verdict)
    );

    simd_xgate_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .insn_valid_i (insn_valid_i),
        .hdl_ret_i    (hdl_ret_i),
        .verdict_i    (verdict),
        .attempt_o    (attempt),
        .grant_o      (grant_o),
        .exc_o        (exc_req_o),
        .held_o       (held_o)
    );

endmodule

// File: rtl/simd_xgate_chk.sv
module simd_xgate_chk (
    input logic       clk,
    input logic       rst,
    input logic       insn_valid_i,
    input logic       ctl_em_i,
    input logic       ctl_ts_i,
    input logic       fpx_set_i,
    input logic       fpx_clr_i,
    input logic       hdl_ret_i,
    input logic       grant_o,
    input logic [2:0] exc_req_o,
    input logic       held_o,
    input logic       pend
);

    logic tried;
    assign tried = held_o ? hdl_ret_i : insn_valid_i;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_o, exc_req_o})); // R6

    AST_EM_GIVES_UD: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !held_o && ctl_em_i) |=> (exc_req_o == 3'b001 && !grant_o)); // R1

    AST_TS_GIVES_NM: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !held_o && !ctl_em_i && ctl_ts_i) |=> (exc_req_o == 3'b010 && !grant_o)); // R2

    AST_PEND_GIVES_MF: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !held_o && !ctl_em_i && !ctl_ts_i && pend) |=> (exc_req_o == 3'b100 && held_o)); // R3

    AST_HELD_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (held_o && !hdl_ret_i) |=> (!grant_o && exc_req_o == 3'b000 && held_o)); // R4

    AST_REPLAY_GRANT: assert property (@(posedge clk) disable iff (rst)
        (held_o && hdl_ret_i && !ctl_em_i && !ctl_ts_i && !pend) |=> (grant_o && !held_o)); // R5

    AST_REPLAY_RETRAP: assert property (@(posedge clk) disable iff (rst)
        (held_o && hdl_ret_i && !ctl_em_i && !ctl_ts_i && pend) |=> (exc_req_o == 3'b100 && held_o)); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !fpx_clr_i) |=> pend); // R7

    AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        fpx_set_i |=> pend); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !tried |=> (!grant_o && exc_req_o == 3'b000)); // R8

    AST_IDLE_RET_NOP: assert property (@(posedge clk) disable iff (rst)
        (!held_o && !insn_valid_i && hdl_ret_i) |=> (!grant_o && exc_req_o == 3'b000 && !held_o)); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!grant_o && exc_req_o == 3'b000 && !held_o && !pend)); // R9

endmodule

bind simd_xgate simd_xgate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .insn_valid_i (insn_valid_i),
    .ctl_em_i     (ctl_em_i),
    .ctl_ts_i     (ctl_ts_i),
    .fpx_set_i    (fpx_set_i),
    .fpx_clr_i    (fpx_clr_i),
    .hdl_ret_i    (hdl_ret_i),
    .grant_o      (grant_o),
    .exc_req_o    (exc_req_o),
    .held_o       (held_o),
    .pend         (fpx_pend)
);

// File: tb/simd_xgate_bench.sv
module simd_xgate_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       insn_valid_i = 1'b0;
    logic       ctl_em_i = 1'b0;
    logic       ctl_ts_i = 1'b0;
    logic       fpx_set_i = 1'b0;
    logic       fpx_clr_i = 1'b0;
    logic       hdl_ret_i = 1'b0;
    logic       grant_o;
    logic [2:0] exc_req_o;
    logic       held_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string tag      = "R9";
    string prev_tag = "R9";

    // Reference model state
    bit       m_held  = 1'b0;
    bit       m_pend  = 1'b0;
    bit       m_grant = 1'b0;
    bit [2:0] m_exc   = 3'b000;

    always #2.5 clk = ~clk;

    simd_xgate u_simd_xgate (
        .clk          (clk),
        .rst          (rst),
        .insn_valid_i (insn_valid_i),
        .ctl_em_i     (ctl_em_i),
        .ctl_ts_i     (ctl_ts_i),
        .fpx_set_i    (fpx_set_i),
        .fpx_clr_i    (fpx_clr_i),
        .hdl_ret_i    (hdl_ret_i),
        .grant_o      (grant_o),
        .exc_req_o    (exc_req_o),
        .held_o       (held_o)
    );

    // Behavioural model: outcome code 0 none, 1 run, 2 UD, 3 NM, 4 MF
    always @(posedge clk) begin
        int  outcome;
        bit  try_now;
        if (rst) begin
            m_held  <= 1'b0;
            m_pend  <= 1'b0;
            m_grant <= 1'b0;
            m_exc   <= 3'b000;
        end else begin
            try_now = m_held ? (hdl_ret_i == 1'b1) : (insn_valid_i == 1'b1);
            outcome = 0;
            if (try_now) begin
                outcome = ctl_em_i ? 2 : ctl_ts_i ? 3 : m_pend ? 4 : 1;
            end
            m_grant <= (outcome == 1);
            m_exc   <= {outcome == 4, outcome == 3, outcome == 2};
            if (outcome != 0) m_held <= (outcome == 4);
            if (fpx_set_i)      m_pend <= 1'b1;
            else if (fpx_clr_i) m_pend <= 1'b0;
        end
    end

    task automatic compare();
        n_checks++;
        if (grant_o !== m_grant || exc_req_o !== m_exc || held_o !== m_held) begin
            n_fails++;
            $display("FAIL %s t=%0t grant/exc/held actual=%b/%b/%b expected=%b/%b/%b",
                     prev_tag, $time, grant_o, exc_req_o, held_o, m_grant, m_exc, m_held);
        end
    endtask

    task automatic cyc(input bit r, input bit v, input bit em, input bit ts,
                       input bit st, input bit cl, input bit rt);
        @(negedge clk);
        compare();
        prev_tag     = tag;
        rst          = r;
        insn_valid_i = v;
        ctl_em_i     = em;
        ctl_ts_i     = ts;
        fpx_set_i    = st;
        fpx_clr_i    = cl;
        hdl_ret_i    = rt;
    endtask

    initial begin
        // R9: reset state with junk on inputs
        tag = "R9";
        cyc(1, 1, 0, 0, 1, 0, 1);
        cyc(1, 1, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R8: idle cycles, then a plain grant
        tag = "R8";
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R1: emulation flag, alone and with task-switched
        tag = "R1";
        cyc(0, 1, 1, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R2: task-switched
        tag = "R2";
        cyc(0, 1, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R6: emulation over pending, task-switched over pending
        tag = "R6";
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 1, 1, 1, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R3: pending error traps and holds
        tag = "R3";
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R4: new instructions ignored while held
        tag = "R4";
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R5: return without clearing retraps
        tag = "R5";
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R7: set and clear together keep pending; return retraps
        tag = "R7";
        cyc(0, 0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R5: clear, then return grants
        tag = "R5";
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R10: return while idle does nothing
        tag = "R10";
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R9: reset while held clears hold and pending
        tag = "R9";
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R6: random mix of every input
        tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 97) == 0,
                ($urandom % 2) == 0,
                ($urandom % 6) == 0,
                ($urandom % 5) == 0,
                ($urandom % 4) == 0,
                ($urandom % 4) == 0,
                ($urandom % 3) == 0);
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule